// File: doc/BRIEF.md
# MSI Write Source Decoder

This block turns an incoming message-signalled interrupt write into a trigger for one local interrupt source. A write carries a 64-bit address, a 16-bit data word and, if wanted, the number of the partitionable endpoint (PE) that sent it. The source number is built by ORing address bits 19..4 with data bits 4..0. The block rejects a source number that is not below the configured source count. When a requester PE is given, the block reads the source's vector entry through a request/response port and only triggers if the PE field of that entry matches the requester.

A second path lets software force an interrupt by writing a register. The written value is used as the address, the data is taken as zero, and no ownership check is made. After that write the block clears a lock register that software acquired beforehand. The block also holds the base offset and the source count of the interrupt range. The count is clamped to the number of sources the block supports. The trigger output is a one-cycle pulse carrying the local source number. Handling of the pending and queued state after the trigger is left to the next stage.

Top module: `msi_src_decoder`

## Requirements
- R1: The source number is ((address >> 4) AND 0xFFFF) bitwise-ORed with (data AND 0x1F); data bits 15..5 and address bits outside 19..4 have no effect.
- R2: A request whose source number is greater than or equal to the stored source count raises `rejErr` for one cycle, one cycle after acceptance, and raises no trigger.
- R3: An in-range MSI with `msiPeValid` low raises `trigValid` for one cycle, one cycle after acceptance, with `trigSrc` equal to the source number.
- R4: An in-range MSI with `msiPeValid` high pulses `entReq` one cycle after acceptance, with `entSrc` set to the source number. `ready` stays low until `entRspValid`. A successful response whose PE equals the requester PE triggers one cycle after the response.
- R5: A successful entry response whose PE differs from the requester PE raises `rejErr` for one cycle and no trigger.
- R6: An entry response with `entRspOk` low ends the request with neither a trigger nor an error, and `ready` returns high.
- R7: A forced-interrupt write uses `ffiValue` as the address and zero as the data, with no entry read. It takes priority over an MSI offered in the same cycle; that MSI is not consumed and is accepted once it is offered again.
- R8: `cfgValid` stores the base and the count, with the count clamped to MAX_SRC (2048), both visible on the outputs one cycle later. A request accepted in the same cycle as the update is judged against the previous count.
- R9: `lockAcquire` sets `ffiLock`. An accepted forced-interrupt write clears it in the next cycle, and this clear wins over an acquire in the same cycle.
- R10: After reset `ready` is high, `trigValid`, `rejErr`, `entReq` and `ffiLock` are low, and the stored count is 0, so every request is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msiValid | input | 1 | MSI write offered |
| msiAddr | input | 64 | MSI write address |
| msiData | input | 16 | MSI write data |
| msiPeValid | input | 1 | Requester PE number is supplied |
| msiPe | input | 8 | Requester PE number |
| ffiValid | input | 1 | Forced-interrupt register write |
| ffiValue | input | 64 | Value written to the forced-interrupt register |
| lockAcquire | input | 1 | Software acquires the forced-interrupt lock |
| cfgValid | input | 1 | Configuration update strobe |
| cfgBase | input | 32 | New base offset of the source range |
| cfgCount | input | 32 | New source count (clamped) |
| entRspValid | input | 1 | Vector entry read response |
| entRspOk | input | 1 | Entry read succeeded |
| entRspPe | input | 8 | PE field of the returned entry |
| ready | output | 1 | Block is idle and accepts a request |
| entReq | output | 1 | Vector entry read request pulse |
| entSrc | output | 11 | Source whose entry is read |
| trigValid | output | 1 | Trigger pulse |
| trigSrc | output | 11 | Local source number of the trigger |
| rejErr | output | 1 | Range or ownership rejection pulse |
| ffiLock | output | 1 | Forced-interrupt lock state |
| baseOut | output | 32 | Stored base offset |
| countOut | output | 12 | Stored, clamped source count |

## Verification
Two pairs of functions can meet in one cycle. The first is a configuration update and a request check: the bench lowers the count from 100 to 10 while an MSI for source 50 is accepted. That MSI must still trigger, and a repeat of it must be rejected. The second is a forced-interrupt write and an MSI offered together: the bench expects the forced source to trigger first, then the held MSI on the following acceptance. A lock acquire in the same cycle as a forced write must leave the lock clear.

// File: rtl/msi_dec_pkg.sv
package msi_dec_pkg;
  typedef enum logic {ST_IDLE, ST_WAIT} decState_t;

  typedef struct packed {
    logic capture;
    logic fire;
    logic fromReg;
    logic reject;
    logic issueRead;
    logic clearLock;
  } ctlStrobe_t;
endpackage

// File: rtl/msi_dec_ctrl.sv
module msi_dec_ctrl
  import msi_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       msiValid,
  input  logic       msiPeValid,
  input  logic       ffiValid,
  input  logic       entRspValid,
  input  logic       entRspOk,
  input  logic       inRange,
  input  logic       peMatch,
  output logic       ready,
  output ctlStrobe_t strobe
);
  decState_t state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (ffiValid || msiValid) begin
          strobe.capture   = 1'b1;
          strobe.clearLock = ffiValid;
          if (!inRange) begin
            strobe.reject = 1'b1;
          end else if (!ffiValid && msiPeValid) begin
            strobe.issueRead = 1'b1;
            nextState        = ST_WAIT;
          end else begin
            strobe.fire = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        strobe.fromReg = 1'b1;
        if (entRspValid) begin
          nextState = ST_IDLE;
          if (entRspOk && peMatch) strobe.fire = 1'b1;
          else if (entRspOk)       strobe.reject = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign ready = (state == ST_IDLE);
endmodule

// File: rtl/msi_dec_dpath.sv
module msi_dec_dpath
  import msi_dec_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int DATA_W  = 16,
  parameter int PE_W    = 8,
  parameter int BASE_W  = 32,
  parameter int CFG_W   = 32,
  parameter int MAX_SRC = 2048,
  localparam int SRC_W  = $clog2(MAX_SRC),
  localparam int CNT_W  = $clog2(MAX_SRC + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              ffiValid,
  input  logic [ADDR_W-1:0] msiAddr,
  input  logic [DATA_W-1:0] msiData,
  input  logic [PE_W-1:0]   msiPe,
  input  logic [ADDR_W-1:0] ffiValue,
  input  logic              lockAcquire,
  input  logic              cfgValid,
  input  logic [BASE_W-1:0] cfgBase,
  input  logic [CFG_W-1:0]  cfgCount,
  input  logic [PE_W-1:0]   entRspPe,
  output logic              inRange,
  output logic              peMatch,
  output logic              entReq,
  output logic [SRC_W-1:0]  entSrc,
  output logic              trigValid,
  output logic [SRC_W-1:0]  trigSrc,
  output logic              rejErr,
  output logic              ffiLock,
  output logic [BASE_W-1:0] baseOut,
  output logic [CNT_W-1:0]  countOut
);
  localparam int FIELD_W = 16;
  localparam int FIELD_LSB = 4;
  localparam int LOW_W = 5;

  logic [ADDR_W-1:0]  addrSel;
  logic [DATA_W-1:0]  dataSel;
  logic [FIELD_W-1:0] srcComb;
  logic [SRC_W-1:0]   srcReg;
  logic [PE_W-1:0]    peReg;
  logic [CNT_W-1:0]   countClamp;

  always_comb begin
    addrSel = ffiValid ? ffiValue : msiAddr;
    dataSel = ffiValid ? '0 : msiData;
    srcComb = addrSel[FIELD_LSB +: FIELD_W] | {{(FIELD_W-LOW_W){1'b0}}, dataSel[LOW_W-1:0]};
    inRange = 32'(srcComb) < 32'(countOut);
    peMatch = (entRspPe == peReg);
    countClamp = (cfgCount > CFG_W'(MAX_SRC)) ? CNT_W'(MAX_SRC) : cfgCount[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigValid <= 1'b0;
      rejErr    <= 1'b0;
      entReq    <= 1'b0;
      trigSrc   <= '0;
      srcReg    <= '0;
      peReg     <= '0;
      ffiLock   <= 1'b0;
      baseOut   <= '0;
      countOut  <= '0;
    end else begin
      trigValid <= strobe.fire;
      rejErr    <= strobe.reject;
      entReq    <= strobe.issueRead;
      if (strobe.fire) trigSrc <= strobe.fromReg ? srcReg : srcComb[SRC_W-1:0];
      if (strobe.capture) begin
        srcReg <= srcComb[SRC_W-1:0];
        peReg  <= msiPe;
      end
      if (strobe.clearLock) ffiLock <= 1'b0;
      else if (lockAcquire) ffiLock <= 1'b1;
      if (cfgValid) begin
        baseOut  <= cfgBase;
        countOut <= countClamp;
      end
    end
  end

  assign entSrc = srcReg;
endmodule

// File: rtl/msi_src_decoder.sv
module msi_src_decoder
  import msi_dec_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int DATA_W  = 16,
  parameter int PE_W    = 8,
  parameter int BASE_W  = 32,
  parameter int CFG_W   = 32,
  parameter int MAX_SRC = 2048,
  localparam int SRC_W  = $clog2(MAX_SRC),
  localparam int CNT_W  = $clog2(MAX_SRC + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msiValid,
  input  logic [ADDR_W-1:0] msiAddr,
  input  logic [DATA_W-1:0] msiData,
  input  logic              msiPeValid,
  input  logic [PE_W-1:0]   msiPe,
  input  logic              ffiValid,
  input  logic [ADDR_W-1:0] ffiValue,
  input  logic              lockAcquire,
  input  logic              cfgValid,
  input  logic [BASE_W-1:0] cfgBase,
  input  logic [CFG_W-1:0]  cfgCount,
  input  logic              entRspValid,
  input  logic              entRspOk,
  input  logic [PE_W-1:0]   entRspPe,
  output logic              ready,
  output logic              entReq,
  output logic [SRC_W-1:0]  entSrc,
  output logic              trigValid,
  output logic [SRC_W-1:0]  trigSrc,
  output logic              rejErr,
  output logic              ffiLock,
  output logic [BASE_W-1:0] baseOut,
  output logic [CNT_W-1:0]  countOut
);
  ctlStrobe_t strobe;
  logic inRange, peMatch;

  msi_dec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .msiValid(msiValid), .msiPeValid(msiPeValid),
    .ffiValid(ffiValid), .entRspValid(entRspValid), .entRspOk(entRspOk),
    .inRange(inRange), .peMatch(peMatch), .ready(ready), .strobe(strobe)
  );

  msi_dec_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PE_W(PE_W), .BASE_W(BASE_W),
    .CFG_W(CFG_W), .MAX_SRC(MAX_SRC)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ffiValid(ffiValid),
    .msiAddr(msiAddr), .msiData(msiData), .msiPe(msiPe), .ffiValue(ffiValue),
    .lockAcquire(lockAcquire), .cfgValid(cfgValid), .cfgBase(cfgBase),
    .cfgCount(cfgCount), .entRspPe(entRspPe), .inRange(inRange),
    .peMatch(peMatch), .entReq(entReq), .entSrc(entSrc), .trigValid(trigValid),
    .trigSrc(trigSrc), .rejErr(rejErr), .ffiLock(ffiLock), .baseOut(baseOut),
    .countOut(countOut)
  );
endmodule

// File: rtl/msi_src_decoder_chk.sv
module msi_src_decoder_chk #(
  parameter int MAX_SRC = 2048,
  localparam int CNT_W  = $clog2(MAX_SRC + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             ready,
  input logic             ffiValid,
  input logic             entRspValid,
  input logic             entRspOk,
  input logic             entReq,
  input logic             trigValid,
  input logic             rejErr,
  input logic             ffiLock,
  input logic [CNT_W-1:0] countOut
);
  // R2
  trig_rej_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(trigValid && rejErr));

  // R4
  busy_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    entReq |-> !ready);

  // R6
  read_fail_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && entRspValid && !entRspOk) |=> (!trigValid && !rejErr && ready));

  // R7
  ffi_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && ffiValid) |=> (ready && !entReq));

  // R8
  count_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    32'(countOut) <= MAX_SRC);

  // R9
  lock_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && ffiValid) |=> !ffiLock);
endmodule

bind msi_src_decoder msi_src_decoder_chk #(.MAX_SRC(MAX_SRC)) u_chk (
  .clk(clk), .rstN(rstN), .ready(ready), .ffiValid(ffiValid),
  .entRspValid(entRspValid), .entRspOk(entRspOk), .entReq(entReq),
  .trigValid(trigValid), .rejErr(rejErr), .ffiLock(ffiLock), .countOut(countOut)
);

// File: tb/msi_src_decoder_bench.sv
`timescale 1ns/1ps
module msi_src_decoder_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        msiValid = 1'b0, msiPeValid = 1'b0, ffiValid = 1'b0;
  logic [63:0] msiAddr = '0, ffiValue = '0;
  logic [15:0] msiData = '0;
  logic [7:0]  msiPe = '0, entRspPe = '0;
  logic        lockAcquire = 1'b0, cfgValid = 1'b0;
  logic [31:0] cfgBase = '0, cfgCount = '0;
  logic        entRspValid = 1'b0, entRspOk = 1'b0;
  logic        ready, entReq, trigValid, rejErr, ffiLock;
  logic [10:0] entSrc, trigSrc;
  logic [31:0] baseOut;
  logic [11:0] countOut;
  int          nChecks = 0, nFails = 0;

  always #4 clk = ~clk;

  msi_src_decoder u_msi_src_decoder (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic endRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  task automatic configure(input logic [31:0] base, input logic [31:0] cnt);
    @(negedge clk);
    cfgValid = 1'b1; cfgBase = base; cfgCount = cnt;
    @(negedge clk);
    cfgValid = 1'b0;
  endtask

  // Offers an MSI for one cycle; outputs of the acceptance are visible on return.
  task automatic sendMsi(input logic [63:0] a, input logic [15:0] d,
                         input logic peV, input logic [7:0] pe);
    @(negedge clk);
    msiValid = 1'b1; msiAddr = a; msiData = d; msiPeValid = peV; msiPe = pe;
    @(negedge clk);
    msiValid = 1'b0; msiPeValid = 1'b0;
  endtask

  task automatic testReset();
    chk("R10 ready", ready, 1);
    chk("R10 trig", trigValid, 0);
    chk("R10 rej", rejErr, 0);
    chk("R10 lock", ffiLock, 0);
    chk("R10 count", countOut, 0);
    sendMsi(64'h0, 16'h0, 1'b0, 8'h0);
    chk("R10 zero count rejects", rejErr, 1);
    chk("R10 zero count no trig", trigValid, 0);
  endtask

  task automatic testConfig();
    configure(32'h200, 32'd5000);
    chk("R8 count clamped", countOut, 2048);
    chk("R8 base", baseOut, 32'h200);
  endtask

  task automatic testSourceForm();
    sendMsi(64'h120, 16'h0003, 1'b0, 8'h0);
    chk("R1 R3 or-form trig", trigValid, 1);
    chk("R1 or-form src", trigSrc, 19);
    sendMsi(64'h120, 16'hFFE3, 1'b0, 8'h0);
    chk("R1 upper data ignored", trigSrc, 19);
    sendMsi(64'hF_0000_0010, 16'h0, 1'b0, 8'h0);
    chk("R1 high addr ignored", trigSrc, 1);
    @(negedge clk);
    chk("R3 single pulse", trigValid, 0);
  endtask

  task automatic testRange();
    sendMsi(64'h7FF0, 16'h0, 1'b0, 8'h0);
    chk("R2 last source triggers", trigValid, 1);
    chk("R2 last source value", trigSrc, 2047);
    sendMsi(64'h8000, 16'h0, 1'b0, 8'h0);
    chk("R2 count rejected", rejErr, 1);
    chk("R2 no trig", trigValid, 0);
  endtask

  task automatic entryCase(input logic ok, input logic [7:0] pe,
                           input logic expTrig, input logic expRej, input string req);
    sendMsi(64'hA0, 16'h0, 1'b1, 8'h07);
    chk({req, " entReq"}, entReq, 1);
    chk({req, " entSrc"}, entSrc, 10);
    chk({req, " busy"}, ready, 0);
    chk({req, " no early trig"}, trigValid, 0);
    entRspValid = 1'b1; entRspOk = ok; entRspPe = pe;
    @(negedge clk);
    entRspValid = 1'b0;
    chk({req, " trig"}, trigValid, expTrig);
    chk({req, " rej"}, rejErr, expRej);
    if (expTrig) chk({req, " src"}, trigSrc, 10);
    chk({req, " ready again"}, ready, 1);
  endtask

  task automatic testFfi();
    @(negedge clk);
    lockAcquire = 1'b1;
    @(negedge clk);
    lockAcquire = 1'b0;
    chk("R9 lock set", ffiLock, 1);
    // forced write together with an MSI carrying a PE
    ffiValid = 1'b1; ffiValue = 64'h50;
    msiValid = 1'b1; msiAddr = 64'h300; msiData = '0; msiPeValid = 1'b1; msiPe = 8'h3;
    @(negedge clk);
    ffiValid = 1'b0;
    chk("R7 forced trig", trigValid, 1);
    chk("R7 forced src", trigSrc, 5);
    chk("R7 no entry read", entReq, 0);
    chk("R9 lock cleared", ffiLock, 0);
    msiPeValid = 1'b0;
    @(negedge clk);
    msiValid = 1'b0;
    chk("R7 held MSI taken", trigSrc, 48);
    // data forced to zero: ffiValue low bits have no data contribution
    @(negedge clk);
    lockAcquire = 1'b1; ffiValid = 1'b1; ffiValue = 64'h63;
    @(negedge clk);
    lockAcquire = 1'b0; ffiValid = 1'b0;
    chk("R9 clear beats acquire", ffiLock, 0);
    chk("R7 zero data src", trigSrc, 6);
  endtask

  task automatic testCfgCollision();
    configure(32'h0, 32'd100);
    @(negedge clk);
    cfgValid = 1'b1; cfgCount = 32'd10;
    msiValid = 1'b1; msiAddr = 64'h320; msiData = '0; msiPeValid = 1'b0;
    @(negedge clk);
    cfgValid = 1'b0; msiValid = 1'b0;
    chk("R8 old count applies", trigValid, 1);
    chk("R8 old count src", trigSrc, 50);
    chk("R8 new count stored", countOut, 10);
    sendMsi(64'h320, 16'h0, 1'b0, 8'h0);
    chk("R8 new count rejects", rejErr, 1);
  endtask

  initial begin
    #(8 * 20000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    endRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testConfig();
    testSourceForm();
    testRange();
    entryCase(1'b1, 8'h07, 1'b1, 1'b0, "R4 match");
    entryCase(1'b1, 8'h09, 1'b0, 1'b1, "R5 mismatch");
    entryCase(1'b0, 8'h07, 1'b0, 1'b0, "R6 read fail");
    testFfi();
    testCfgCollision();
    repeat (2) @(negedge clk);
    endRun();
  end
endmodule